// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between the wakeup logic and the functional units of an out-of-order core. Instructions that have become ready arrive one per cycle. Each one carries a sequence number, an operation class and an opaque tag. The block files each instruction into a small queue owned by its class. That queue stays sorted by age, so its head is always the oldest entry of the class. Every cycle the heads of all classes are ranked against each other by age. Up to `ISSUE_W` grants are then handed out, the oldest eligible head first, and no class receives more than one grant.

A class whose functional unit reports busy is passed over, and selection moves on to the next-oldest class in the same cycle. Each class has a saturating counter that records how many cycles it held a ready instruction while its unit was busy. A squash request names a boundary sequence number. In a single cycle it discards every queued instruction younger than that boundary, and no instruction is granted in that cycle.

Top module: `oldest_issue_select`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, every class queue is empty, `grant_vld` is all zero and every `busy_cnt` field is zero.
- R2: Within one class, instructions are granted in sequence-number order, oldest first, whatever order they were pushed in.
- R3: Each cycle the grants go to the oldest eligible class heads. Slot 0 carries the oldest of them, and each following slot carries a strictly younger instruction. `grant_cls`, `grant_seq` and `grant_tag` of slot k sit at bits `[k*W +: W]` of their buses.
- R4: At most `ISSUE_W` grants are given per cycle and at most one per class. The valid slots form an unbroken run starting at slot 0.
- R5: A class whose `unit_busy` bit is high receives no grant. Its slot goes to the next-oldest eligible class in the same cycle.
- R6: The field `busy_cnt[c*CNT_W +: CNT_W]` increases by one in each cycle in which class c holds an instruction and `unit_busy[c]` is high. It stops at its all-ones value and does not change in any other cycle.
- R7: Sequence number a is older than b when the most significant bit of `(a - b) mod 2^SEQ_W` is set. Age ordering therefore stays correct across the wrap from all-ones to zero.
- R8: In a cycle with `squash_vld` high, no grant is given. Every queued instruction younger than `squash_seq` is removed, while the boundary instruction and older ones stay. A push in that cycle that is younger than `squash_seq` is dropped.
- R9: An instruction pushed in cycle t is visible to selection from cycle t+1 on. Grants are driven combinationally from the registered queue heads and the current `unit_busy` and `squash_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_vld | input | 1 | A ready instruction is presented this cycle |
| push_cls | input | CLS_W | Operation class of the pushed instruction |
| push_seq | input | SEQ_W | Sequence number of the pushed instruction |
| push_tag | input | TAG_W | Opaque tag returned with the grant |
| unit_busy | input | NCLS | Per-class functional unit busy flags |
| squash_vld | input | 1 | Squash request this cycle |
| squash_seq | input | SEQ_W | Squash boundary; younger entries are removed |
| grant_vld | output | ISSUE_W | Per-slot grant valid |
| grant_cls | output | ISSUE_W*CLS_W | Class of each granted instruction |
| grant_seq | output | ISSUE_W*SEQ_W | Sequence number of each granted instruction |
| grant_tag | output | ISSUE_W*TAG_W | Tag of each granted instruction |
| busy_cnt | output | NCLS*CNT_W | Per-class saturating busy-event counters |

## Verification
The checks take for granted that no push reaches a class queue that is already full, unless that queue is granting its head in the same cycle. They also assume that live sequence numbers are unique and span less than half the sequence space. Without that, the order checks on grant slots would have no meaning. The stimulus keeps a model of each queue's occupancy and skips any push that would overfill a queue. It also holds back new sequence numbers whenever the oldest live instruction is close to half the range away. After a squash, allocation restarts just past the boundary, so freed numbers are reused only once the entries holding them have been discarded.

// File: rtl/issel_pkg.sv
package issel_pkg;

   // Index width for a count range of n values, never below one bit.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/issel_class_queue.sv
module issel_class_queue
   import issel_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned SEQ_W = 8,
   parameter int unsigned TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop,
   input  logic             squash,
   input  logic [SEQ_W-1:0] squash_seq,
   input  logic             push,
   input  logic [SEQ_W-1:0] push_seq,
   input  logic [TAG_W-1:0] push_tag,
   output logic             head_vld,
   output logic [SEQ_W-1:0] head_seq,
   output logic [TAG_W-1:0] head_tag,
   output logic             full
);

   localparam int unsigned POS_W = idx_bits(DEPTH + 1);

   function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
      logic [SEQ_W-1:0] d;
      d = a - b;
      return d[SEQ_W-1];
   endfunction

   logic [DEPTH-1:0] vld_q, vld_d;
   logic [SEQ_W-1:0] seq_q [DEPTH];
   logic [SEQ_W-1:0] seq_d [DEPTH];
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [TAG_W-1:0] tag_d [DEPTH];

   logic [DEPTH-1:0] a_vld, b_vld, p_vld;
   logic [SEQ_W-1:0] a_seq [DEPTH];
   logic [TAG_W-1:0] a_tag [DEPTH];
   logic [SEQ_W-1:0] p_seq [DEPTH];
   logic [TAG_W-1:0] p_tag [DEPTH];
   logic             ins;
   logic [POS_W-1:0] pos;

   // Stage 1: drop the head when it is granted.
   always_comb begin
      for (int i = 0; i < DEPTH - 1; i++) begin
         a_vld[i] = pop ? vld_q[i+1] : vld_q[i];
         a_seq[i] = pop ? seq_q[i+1] : seq_q[i];
         a_tag[i] = pop ? tag_q[i+1] : tag_q[i];
      end
      a_vld[DEPTH-1] = pop ? 1'b0 : vld_q[DEPTH-1];
      a_seq[DEPTH-1] = seq_q[DEPTH-1];
      a_tag[DEPTH-1] = tag_q[DEPTH-1];
   end

   // Stage 2: squash clears entries younger than the boundary (always a tail).
   always_comb begin
      for (int i = 0; i < DEPTH; i++)
         b_vld[i] = a_vld[i] & ~(squash & older(squash_seq, a_seq[i]));
   end

   // Stage 3: sorted insertion of the surviving push.
   always_comb begin
      ins = push & ~(squash & older(squash_seq, push_seq));
      pos = '0;
      for (int i = 0; i < DEPTH; i++)
         if (b_vld[i] && older(a_seq[i], push_seq))
            pos = pos + POS_W'(1);
      p_vld[0] = 1'b0;
      p_seq[0] = '0;
      p_tag[0] = '0;
      for (int i = 1; i < DEPTH; i++) begin
         p_vld[i] = b_vld[i-1];
         p_seq[i] = a_seq[i-1];
         p_tag[i] = a_tag[i-1];
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (ins && POS_W'(i) == pos) begin
            vld_d[i] = 1'b1;
            seq_d[i] = push_seq;
            tag_d[i] = push_tag;
         end else if (ins && POS_W'(i) > pos) begin
            vld_d[i] = p_vld[i];
            seq_d[i] = p_seq[i];
            tag_d[i] = p_tag[i];
         end else begin
            vld_d[i] = b_vld[i];
            seq_d[i] = a_seq[i];
            tag_d[i] = a_tag[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            seq_q[i] <= '0;
            tag_q[i] <= '0;
         end
      end else begin
         vld_q <= vld_d;
         for (int i = 0; i < DEPTH; i++) begin
            seq_q[i] <= seq_d[i];
            tag_q[i] <= tag_d[i];
         end
      end
   end

   assign head_vld = vld_q[0];
   assign head_seq = seq_q[0];
   assign head_tag = tag_q[0];
   assign full     = vld_q[DEPTH-1];

endmodule

// File: rtl/issel_age_pick.sv
module issel_age_pick
   import issel_pkg::*;
#(
   parameter int unsigned NCLS    = 4,
   parameter int unsigned ISSUE_W = 2,
   parameter int unsigned SEQ_W   = 8,
   localparam int unsigned CLS_W  = idx_bits(NCLS)
) (
   input  logic [NCLS-1:0]    head_vld,
   input  logic [SEQ_W-1:0]   head_seq [NCLS],
   input  logic [NCLS-1:0]    busy,
   input  logic               hold,
   output logic [NCLS-1:0]    issue,
   output logic [ISSUE_W-1:0] slot_vld,
   output logic [CLS_W-1:0]   slot_cls [ISSUE_W]
);

   localparam int unsigned RANK_W = idx_bits(NCLS + 1);

   function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
      logic [SEQ_W-1:0] d;
      d = a - b;
      return d[SEQ_W-1];
   endfunction

   logic [NCLS-1:0]   elig;
   logic [RANK_W-1:0] rank [NCLS];

   assign elig = head_vld & ~busy & {NCLS{~hold}};

   // Age order of eligible heads: rank = number of eligible heads older.
   for (genvar c = 0; c < NCLS; c++) begin : g_rank
      always_comb begin
         rank[c] = '0;
         for (int d = 0; d < NCLS; d++)
            if (d != c && elig[d] && older(head_seq[d], head_seq[c]))
               rank[c] = rank[c] + RANK_W'(1);
      end
      assign issue[c] = elig[c] && (rank[c] < RANK_W'(ISSUE_W));
   end

   for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
      always_comb begin
         slot_vld[k] = 1'b0;
         slot_cls[k] = '0;
         for (int c = 0; c < NCLS; c++)
            if (issue[c] && rank[c] == RANK_W'(k)) begin
               slot_vld[k] = 1'b1;
               slot_cls[k] = CLS_W'(c);
            end
      end
   end

endmodule

// File: rtl/issel_busy_ctr.sv
module issel_busy_ctr #(
   parameter int unsigned NCLS  = 4,
   parameter int unsigned CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCLS-1:0]      hit,
   output logic [NCLS*CNT_W-1:0] cnt
);

   for (genvar c = 0; c < NCLS; c++) begin : g_ctr
      logic [CNT_W-1:0] val_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            val_q <= '0;
         else if (hit[c] && val_q != {CNT_W{1'b1}})
            val_q <= val_q + CNT_W'(1);
      end
      assign cnt[c*CNT_W +: CNT_W] = val_q;
   end

endmodule

// File: rtl/oldest_issue_select.sv
module oldest_issue_select
   import issel_pkg::*;
#(
   parameter int unsigned NCLS    = 4,
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned ISSUE_W = 2,
   parameter int unsigned SEQ_W   = 8,
   parameter int unsigned TAG_W   = 6,
   parameter int unsigned CNT_W   = 16,
   localparam int unsigned CLS_W  = idx_bits(NCLS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push_vld,
   input  logic [CLS_W-1:0]         push_cls,
   input  logic [SEQ_W-1:0]         push_seq,
   input  logic [TAG_W-1:0]         push_tag,
   input  logic [NCLS-1:0]          unit_busy,
   input  logic                     squash_vld,
   input  logic [SEQ_W-1:0]         squash_seq,
   output logic [ISSUE_W-1:0]       grant_vld,
   output logic [ISSUE_W*CLS_W-1:0] grant_cls,
   output logic [ISSUE_W*SEQ_W-1:0] grant_seq,
   output logic [ISSUE_W*TAG_W-1:0] grant_tag,
   output logic [NCLS*CNT_W-1:0]    busy_cnt
);

   if (NCLS < 2) begin : g_bad_ncls
      $error("NCLS must be at least 2");
   end
   if (ISSUE_W < 1 || ISSUE_W > NCLS) begin : g_bad_width
      $error("ISSUE_W must lie in 1..NCLS");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (SEQ_W < 2 || CNT_W < 1) begin : g_bad_bits
      $error("SEQ_W must be at least 2 and CNT_W at least 1");
   end

   logic [NCLS-1:0]    hv;      // class present in the age order
   logic [NCLS-1:0]    q_full;
   logic [NCLS-1:0]    issue;
   logic [SEQ_W-1:0]   hseq [NCLS];
   logic [TAG_W-1:0]   htag [NCLS];
   logic [CLS_W-1:0]   slot_cls [ISSUE_W];
   logic [ISSUE_W-1:0] slot_vld;

   for (genvar c = 0; c < NCLS; c++) begin : g_q
      issel_class_queue #(
         .DEPTH (DEPTH),
         .SEQ_W (SEQ_W),
         .TAG_W (TAG_W)
      ) u_q (
         .clk        (clk),
         .rst_n      (rst_n),
         .pop        (issue[c]),
         .squash     (squash_vld),
         .squash_seq (squash_seq),
         .push       (push_vld && push_cls == CLS_W'(c)),
         .push_seq   (push_seq),
         .push_tag   (push_tag),
         .head_vld   (hv[c]),
         .head_seq   (hseq[c]),
         .head_tag   (htag[c]),
         .full       (q_full[c])
      );
   end

   issel_age_pick #(
      .NCLS    (NCLS),
      .ISSUE_W (ISSUE_W),
      .SEQ_W   (SEQ_W)
   ) u_pick (
      .head_vld (hv),
      .head_seq (hseq),
      .busy     (unit_busy),
      .hold     (squash_vld),
      .issue    (issue),
      .slot_vld (slot_vld),
      .slot_cls (slot_cls)
   );

   issel_busy_ctr #(
      .NCLS  (NCLS),
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hv & unit_busy),
      .cnt   (busy_cnt)
   );

   assign grant_vld = slot_vld;

   for (genvar k = 0; k < ISSUE_W; k++) begin : g_out
      always_comb begin
         grant_cls[k*CLS_W +: CLS_W] = slot_cls[k];
         grant_seq[k*SEQ_W +: SEQ_W] = slot_vld[k] ? hseq[slot_cls[k]] : '0;
         grant_tag[k*TAG_W +: TAG_W] = slot_vld[k] ? htag[slot_cls[k]] : '0;
      end
   end

endmodule

// File: rtl/issel_chk.sv
module issel_chk #(
   parameter int unsigned NCLS    = 4,
   parameter int unsigned ISSUE_W = 2,
   parameter int unsigned SEQ_W   = 8,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned CLS_W   = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     push_vld,
   input logic [CLS_W-1:0]         push_cls,
   input logic [NCLS-1:0]          unit_busy,
   input logic                     squash_vld,
   input logic [ISSUE_W-1:0]       grant_vld,
   input logic [ISSUE_W*CLS_W-1:0] grant_cls,
   input logic [ISSUE_W*SEQ_W-1:0] grant_seq,
   input logic [NCLS*CNT_W-1:0]    busy_cnt,
   input logic [NCLS-1:0]          hv,
   input logic [NCLS-1:0]          q_full,
   input logic [NCLS-1:0]          issue
);

   function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
      logic [SEQ_W-1:0] d;
      d = a - b;
      return d[SEQ_W-1];
   endfunction

   // R8
   squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      squash_vld |-> grant_vld == '0);

   // R2 (input rule: no push into a full queue that is not draining)
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_vld && q_full[push_cls]) |-> issue[push_cls]);

   for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
      // R5
      busy_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
         grant_vld[k] |-> !unit_busy[grant_cls[k*CLS_W +: CLS_W]]);
      // R4
      grant_has_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
         grant_vld[k] |-> hv[grant_cls[k*CLS_W +: CLS_W]]);
      if (k > 0) begin : g_pair
         // R4
         slot_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant_vld[k] |-> grant_vld[k-1]);
         // R3
         slot_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant_vld[k] |-> older(grant_seq[(k-1)*SEQ_W +: SEQ_W], grant_seq[k*SEQ_W +: SEQ_W]));
         for (genvar j = 0; j < k; j++) begin : g_dist
            // R4
            one_per_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
               grant_vld[k] |-> grant_cls[k*CLS_W +: CLS_W] != grant_cls[j*CLS_W +: CLS_W]);
         end
      end
   end

   for (genvar c = 0; c < NCLS; c++) begin : g_cls
      // R6
      busy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hv[c] && unit_busy[c] && busy_cnt[c*CNT_W +: CNT_W] != {CNT_W{1'b1}})
         |=> busy_cnt[c*CNT_W +: CNT_W] == $past(busy_cnt[c*CNT_W +: CNT_W]) + CNT_W'(1));
      // R6
      busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(hv[c] && unit_busy[c]) |=> $stable(busy_cnt[c*CNT_W +: CNT_W]));
   end

endmodule

bind oldest_issue_select issel_chk #(
   .NCLS    (NCLS),
   .ISSUE_W (ISSUE_W),
   .SEQ_W   (SEQ_W),
   .CNT_W   (CNT_W),
   .CLS_W   (CLS_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_vld   (push_vld),
   .push_cls   (push_cls),
   .unit_busy  (unit_busy),
   .squash_vld (squash_vld),
   .grant_vld  (grant_vld),
   .grant_cls  (grant_cls),
   .grant_seq  (grant_seq),
   .busy_cnt   (busy_cnt),
   .hv         (hv),
   .q_full     (q_full),
   .issue      (issue)
);

// File: tb/sim_oldest_issue_select.sv
`timescale 1ns/1ps
module sim_oldest_issue_select;

   localparam int C  = 4;
   localparam int D  = 4;
   localparam int W  = 2;
   localparam int SW = 8;
   localparam int TW = 6;
   localparam int CW = 6;
   localparam int LW = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              p_vld = 1'b0;
   logic [LW-1:0]     p_cls = '0;
   logic [SW-1:0]     p_seq = '0;
   logic [TW-1:0]     p_tag = '0;
   logic [C-1:0]      busy = '0;
   logic              sq_vld = 1'b0;
   logic [SW-1:0]     sq_seq = '0;
   logic [W-1:0]      g_vld;
   logic [W*LW-1:0]   g_cls;
   logic [W*SW-1:0]   g_seq;
   logic [W*TW-1:0]   g_tag;
   logic [C*CW-1:0]   b_cnt;

   always #4 clk = ~clk;

   oldest_issue_select #(
      .NCLS(C), .DEPTH(D), .ISSUE_W(W), .SEQ_W(SW), .TAG_W(TW), .CNT_W(CW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .push_vld(p_vld), .push_cls(p_cls),
      .push_seq(p_seq), .push_tag(p_tag), .unit_busy(busy),
      .squash_vld(sq_vld), .squash_seq(sq_seq), .grant_vld(g_vld),
      .grant_cls(g_cls), .grant_seq(g_seq), .grant_tag(g_tag), .busy_cnt(b_cnt)
   );

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   // Bench model
   int          m_n [C];
   logic [SW-1:0] m_seq [C][D];
   logic [TW-1:0] m_tag [C][D];
   int          m_cnt [C];
   int          e_n;
   int          e_cls [W];

   logic [SW-1:0] next_seq;
   bit            have_def = 1'b0;
   logic [SW-1:0] def_seq;
   int            def_cls;

   function automatic bit older(input logic [SW-1:0] a, input logic [SW-1:0] b);
      logic [SW-1:0] d;
      d = a - b;
      return d[SW-1];
   endfunction

   function automatic int head_idx(input int c);
      int h = 0;
      for (int i = 1; i < m_n[c]; i++)
         if (older(m_seq[c][i], m_seq[c][h])) h = i;
      return h;
   endfunction

   function automatic void drop_idx(input int c, input int i);
      m_seq[c][i] = m_seq[c][m_n[c]-1];
      m_tag[c][i] = m_tag[c][m_n[c]-1];
      m_n[c] = m_n[c] - 1;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input string lbl);
      bit taken [C];
      int hi;
      #2;
      // expected grants: oldest eligible heads, one per class
      e_n = 0;
      for (int c = 0; c < C; c++) taken[c] = 1'b0;
      for (int k = 0; k < W; k++) begin
         int best = -1;
         for (int c = 0; c < C; c++) begin
            if (m_n[c] > 0 && !busy[c] && !sq_vld && !taken[c]) begin
               if (best < 0) best = c;
               else if (older(m_seq[c][head_idx(c)], m_seq[best][head_idx(best)])) best = c;
            end
         end
         if (best >= 0) begin
            taken[best] = 1'b1;
            e_cls[k] = best;
            e_n++;
         end
      end
      for (int k = 0; k < W; k++) begin
         logic [63:0] act, exp;
         act = {g_vld[k], 6'd0, g_cls[k*LW +: LW], 6'd0, g_seq[k*SW +: SW], 2'd0, g_tag[k*TW +: TW]};
         if (k < e_n) begin
            hi = head_idx(e_cls[k]);
            exp = {1'b1, 6'd0, LW'(e_cls[k]), 6'd0, m_seq[e_cls[k]][hi], 2'd0, m_tag[e_cls[k]][hi]};
         end else begin
            exp = {1'b0, 6'd0, g_cls[k*LW +: LW], 6'd0, g_seq[k*SW +: SW], 2'd0, g_tag[k*TW +: TW]};
         end
         chk(act == exp, lbl, $sformatf("grant slot %0d R3 R4", k), act, exp);
      end
      for (int c = 0; c < C; c++)
         chk(b_cnt[c*CW +: CW] == CW'(m_cnt[c]), "R6", $sformatf("busy_cnt class %0d", c),
             64'(b_cnt[c*CW +: CW]), 64'(m_cnt[c]));
      @(posedge clk);
      for (int c = 0; c < C; c++)
         if (m_n[c] > 0 && busy[c] && m_cnt[c] < (1 << CW) - 1) m_cnt[c]++;
      for (int k = 0; k < e_n; k++) drop_idx(e_cls[k], head_idx(e_cls[k]));
      if (sq_vld) begin
         for (int c = 0; c < C; c++)
            for (int i = m_n[c] - 1; i >= 0; i--)
               if (older(sq_seq, m_seq[c][i])) drop_idx(c, i);
      end
      if (p_vld && !(sq_vld && older(sq_seq, p_seq))) begin
         m_seq[p_cls][m_n[p_cls]] = p_seq;
         m_tag[p_cls][m_n[p_cls]] = p_tag;
         m_n[p_cls]++;
      end
      @(negedge clk);
      p_vld  = 1'b0;
      sq_vld = 1'b0;
   endtask

   task automatic put(input int cls, input logic [SW-1:0] s, input logic [TW-1:0] t);
      p_vld = 1'b1;
      p_cls = LW'(cls);
      p_seq = s;
      p_tag = t;
   endtask

   function automatic int span();
      int m = 0;
      for (int c = 0; c < C; c++)
         for (int i = 0; i < m_n[c]; i++)
            if (int'(8'(next_seq - m_seq[c][i])) > m) m = int'(8'(next_seq - m_seq[c][i]));
      if (have_def && int'(8'(next_seq - def_seq)) > m) m = int'(8'(next_seq - def_seq));
      return m;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd7));
      for (int c = 0; c < C; c++) begin m_n[c] = 0; m_cnt[c] = 0; end
      repeat (3) @(negedge clk);
      chk(g_vld == '0, "R1", "grant_vld in reset", 64'(g_vld), 0);
      chk(b_cnt == '0, "R1", "busy_cnt in reset", 64'(b_cnt), 0);
      rst_n = 1'b1;
      #2;
      chk(g_vld == '0, "R1", "grant_vld after reset", 64'(g_vld), 0);
      @(negedge clk);

      // R9: a push is not granted in its own cycle
      put(0, 8'd5, 6'd1);
      cyc("R9");
      // R2: out-of-order pushes into one class drain oldest first
      busy = 4'b0001;
      put(0, 8'd3, 6'd2);
      cyc("R2");
      put(0, 8'd4, 6'd3);
      cyc("R2");
      busy = '0;
      repeat (4) cyc("R2");

      // R7: ordering across the wrap
      busy = 4'b1111;
      put(1, 8'hFE, 6'd4); cyc("R7");
      put(2, 8'h02, 6'd5); cyc("R7");
      put(3, 8'hFC, 6'd6); cyc("R7");
      busy = '0;
      repeat (3) cyc("R7");

      // R5: busy oldest class is skipped, next-oldest granted
      busy = 4'b1111;
      put(0, 8'd10, 6'd7); cyc("R5");
      put(1, 8'd11, 6'd8); cyc("R5");
      put(2, 8'd12, 6'd9); cyc("R5");
      busy = 4'b0001;
      cyc("R5");
      busy = '0;
      repeat (2) cyc("R5");

      // R8: squash removes younger entries and drops a younger push
      busy = 4'b1111;
      put(0, 8'd24, 6'd10); cyc("R8");
      put(0, 8'd20, 6'd11); cyc("R8");
      put(0, 8'd22, 6'd12); cyc("R8");
      put(1, 8'd21, 6'd13); cyc("R8");
      put(1, 8'd23, 6'd14); cyc("R8");
      busy = '0;
      sq_vld = 1'b1; sq_seq = 8'd22;
      put(2, 8'd25, 6'd15);
      cyc("R8");
      sq_vld = 1'b1; sq_seq = 8'd22;
      put(2, 8'd18, 6'd16);
      cyc("R8");
      repeat (4) cyc("R8");

      // Random phase
      next_seq = 8'd40;
      for (int n = 0; n < 4000; n++) begin
         string lbl;
         int    cls;
         lbl = "R3";
         for (int c = 0; c < C; c++) busy[c] = ($urandom % 4) == 0;
         if (($urandom % 40) == 0) begin
            sq_vld = 1'b1;
            sq_seq = next_seq - 8'd1 - 8'($urandom % 6);
            next_seq = sq_seq + 8'd1;
            if (have_def && older(sq_seq, def_seq)) have_def = 1'b0;
            lbl = "R8";
         end
         if (($urandom % 4) != 0) begin
            if (have_def && ($urandom % 2) == 0) begin
               if (m_n[def_cls] < D) begin
                  put(def_cls, def_seq, 6'($urandom));
                  have_def = 1'b0;
               end
            end else if (span() < 100) begin
               cls = int'($urandom % C);
               if (m_n[cls] < D) begin
                  if (!have_def && ($urandom % 3) == 0) begin
                     def_seq  = next_seq;
                     def_cls  = int'($urandom % C);
                     have_def = 1'b1;
                     put(cls, next_seq + 8'd1, 6'($urandom));
                     next_seq = next_seq + 8'd2;
                     lbl = "R2";
                  end else begin
                     put(cls, next_seq, 6'($urandom));
                     next_seq = next_seq + 8'd1;
                  end
               end
            end
         end
         cyc(lbl);
      end
      busy = '0;
      repeat (8) cyc("R3");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule